// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four shared PCI interrupt request lines of a bus segment and steers each one onto one of sixteen legacy interrupt-controller inputs. Software programs the steering through a small register window. There is one byte-wide route selector for each request line. A selector value that names an existing destination line enables the route. Any value beyond the last line parks the request line so that it drives nothing. Several request lines may share one destination. That destination is then the logical OR of all enabled request lines steered to it.

The router keeps a registered level bitmap with one bit for each pairing of a destination and a request line. On every clock the bitmap is rebuilt from the live request levels and the selectors that will hold after any write in that cycle. A rewrite of a selector therefore releases the old destination and drives the new one on the same edge.

A combinational route query reports, for any request pin, whether it is steered and to which line. A slot helper converts a device's slot number and its INTx pin into the request-line index that the pin is wired to on the board.

Top module: `pirq_router`

## Requirements
- R1: A selector value from 0 to 15 steers its request line to the destination output with that index. The selector for request line p is byte lane p of the register word.
- R2: A selector value from 16 to 255 disables that request line. It then asserts no destination output, whatever its level.
- R3: After reset every selector reads 0x80 and every destination output is low.
- R4: Each destination output is the OR of the levels of all request lines whose selectors currently name it.
- R5: When a write changes a selector, the previously named destination drops on the same clock edge that the new destination rises, provided no other request line holds it.
- R6: Changing the level of a disabled request line changes no destination output.
- R7: The slot helper returns (pin + slot - 1) modulo 4, with pins A to D encoded as 0 to 3.
- R8: The route query for a pin returns enable = 1 and the selector's line number when the selector is below 16. Otherwise it returns enable = 0 and a line field of all ones.
- R9: A write to the selector word (word address 0x18, byte offset 0x60) updates only the byte lanes whose strobes are set. One write with all four strobes set updates all four selectors on the same edge.
- R10: A read at the selector word returns the last written bytes unchanged, including disabling values. A read at any other word address returns zero.
- R11: Destination outputs are registered. They change on the first clock edge after a request-level change or a selector write, and do not change before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 8 | Word address for read and write |
| wr_data | input | 32 | Write data, one selector per byte lane |
| wr_strb | input | 4 | Byte-lane write strobes |
| rd_data | output | 32 | Read data for the word at addr |
| pirq_lvl | input | 4 | Live levels of the four request lines |
| irq_out | output | 16 | Destination interrupt-controller inputs |
| query_pin | input | 2 | Request pin for the route query |
| query_en | output | 1 | Queried route is enabled |
| query_line | output | 4 | Queried destination line, all ones when disabled |
| slot_num | input | 5 | Device slot number for the helper |
| slot_pin | input | 2 | Device INTx pin, A to D as 0 to 3 |
| slot_pirq | output | 2 | Request-line index for that slot and pin |

## Verification
The hardest case to reach from the ports is a selector rewrite while its request line is held high. The old destination must drop on exactly the edge at which the new one rises, and it must stay high when another request line still shares it. Directed phases park two request lines on one destination, raise both, and then move or disable one of them. A long random phase follows. It draws mostly valid selector values with partial strobes and toggles levels at the same time, so writes and level changes often land in one cycle. A behavioural model built from integer route values checks every output on every clock.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
   localparam logic [7:0] ROUTE_OFF_CODE = 8'h80;
   localparam int         PIN_COUNT      = 4;
   localparam int         BYTE_W         = 8;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
   import pirq_router_pkg::*;
#(
   parameter int            NUM_PIRQ  = 4,
   parameter int            SEL_W     = 8,
   parameter int            DATA_W    = 32,
   parameter int            ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_WORD = 8'h18,
   localparam int           STRB_W    = DATA_W / BYTE_W
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [STRB_W-1:0]              wr_strb,
   output logic [DATA_W-1:0]              rd_data,
   output logic [NUM_PIRQ-1:0][SEL_W-1:0] route_q,
   output logic [NUM_PIRQ-1:0][SEL_W-1:0] route_d
);
   logic hit;
   assign hit = (addr == BASE_WORD);

   generate
      for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_sel
         always_comb begin
            route_d[p] = route_q[p];
            if (wr_en && hit && wr_strb[p])
               route_d[p] = wr_data[p*BYTE_W +: SEL_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) route_q[p] <= ROUTE_OFF_CODE;
            else        route_q[p] <= route_d[p];
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (hit) begin
         for (int p = 0; p < NUM_PIRQ; p++)
            rd_data[p*BYTE_W +: SEL_W] = route_q[p];
      end
   end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
   parameter int NUM_PIRQ  = 4,
   parameter int NUM_LINES = 16,
   parameter int SEL_W     = 8
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PIRQ-1:0][SEL_W-1:0] route_d,
   input  logic [NUM_PIRQ-1:0]            pirq_lvl,
   output logic [NUM_LINES-1:0]           irq_out
);
   logic [NUM_LINES-1:0][NUM_PIRQ-1:0] map_q;
   logic [NUM_LINES-1:0][NUM_PIRQ-1:0] map_d;

   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_src
            assign map_d[l][p] = pirq_lvl[p] && (route_d[p] == SEL_W'(l));
         end
         assign irq_out[l] = |map_q[l];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= map_d;
   end
endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query #(
   parameter int NUM_PIRQ  = 4,
   parameter int NUM_LINES = 16,
   parameter int SEL_W     = 8,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int PIN_W    = $clog2(NUM_PIRQ)
)(
   input  logic [NUM_PIRQ-1:0][SEL_W-1:0] route_q,
   input  logic [PIN_W-1:0]               query_pin,
   output logic                           query_en,
   output logic [LINE_W-1:0]              query_line
);
   logic [SEL_W-1:0] sel;
   assign sel = route_q[query_pin];

   always_comb begin
      query_en   = (int'(sel) < NUM_LINES);
      query_line = '1;
      if (query_en) query_line = LINE_W'(int'(sel));
   end
endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
   parameter int SLOT_W     = 5,
   parameter bit SWIZZLE_EN = 1'b1
)(
   input  logic [SLOT_W-1:0] slot_num,
   input  logic [1:0]        slot_pin,
   output logic [1:0]        slot_pirq
);
   generate
      if (SWIZZLE_EN) begin : g_rot
         assign slot_pirq = 2'((int'(slot_pin) + int'(slot_num) + 3) % 4);
      end else begin : g_flat
         assign slot_pirq = slot_pin;
      end
   endgenerate
endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_router_pkg::*;
#(
   parameter int            NUM_PIRQ   = 4,
   parameter int            NUM_LINES  = 16,
   parameter int            SEL_W      = 8,
   parameter int            DATA_W     = 32,
   parameter int            ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] BASE_WORD = 8'h18,
   parameter int            SLOT_W     = 5,
   parameter bit            SWIZZLE_EN = 1'b1,
   localparam int           STRB_W     = DATA_W / BYTE_W,
   localparam int           LINE_W     = $clog2(NUM_LINES),
   localparam int           PIN_W      = $clog2(NUM_PIRQ)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [STRB_W-1:0]    wr_strb,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [NUM_PIRQ-1:0]  pirq_lvl,
   output logic [NUM_LINES-1:0] irq_out,
   input  logic [PIN_W-1:0]     query_pin,
   output logic                 query_en,
   output logic [LINE_W-1:0]    query_line,
   input  logic [SLOT_W-1:0]    slot_num,
   input  logic [1:0]           slot_pin,
   output logic [1:0]           slot_pirq
);
   generate
      if (NUM_PIRQ != PIN_COUNT) begin : g_bad_pirq
         $error("pirq_router: NUM_PIRQ must be 4");
      end
      if (SEL_W != BYTE_W) begin : g_bad_sel
         $error("pirq_router: selectors must be one byte wide");
      end
      if (NUM_PIRQ * SEL_W > DATA_W) begin : g_bad_data
         $error("pirq_router: selectors do not fit the data bus");
      end
      if (NUM_LINES < 2 || NUM_LINES > (1 << SEL_W) - 1) begin : g_bad_lines
         $error("pirq_router: NUM_LINES leaves no disabling code");
      end
      if (int'(ROUTE_OFF_CODE) < NUM_LINES) begin : g_bad_off
         $error("pirq_router: reset code must disable the route");
      end
   endgenerate

   logic [NUM_PIRQ-1:0][SEL_W-1:0] route_q;
   logic [NUM_PIRQ-1:0][SEL_W-1:0] route_d;

   pirq_route_regs #(
      .NUM_PIRQ (NUM_PIRQ), .SEL_W (SEL_W), .DATA_W (DATA_W),
      .ADDR_W (ADDR_W), .BASE_WORD (BASE_WORD)
   ) u_regs (
      .clk, .rst_n, .wr_en, .addr, .wr_data, .wr_strb,
      .rd_data, .route_q, .route_d
   );

   pirq_level_map #(
      .NUM_PIRQ (NUM_PIRQ), .NUM_LINES (NUM_LINES), .SEL_W (SEL_W)
   ) u_map (
      .clk, .rst_n, .route_d, .pirq_lvl, .irq_out
   );

   pirq_route_query #(
      .NUM_PIRQ (NUM_PIRQ), .NUM_LINES (NUM_LINES), .SEL_W (SEL_W)
   ) u_query (
      .route_q, .query_pin, .query_en, .query_line
   );

   pirq_slot_swizzle #(
      .SLOT_W (SLOT_W), .SWIZZLE_EN (SWIZZLE_EN)
   ) u_swz (
      .slot_num, .slot_pin, .slot_pirq
   );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int            NUM_PIRQ  = 4,
   parameter int            NUM_LINES = 16,
   parameter int            SEL_W     = 8,
   parameter int            ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_WORD = 8'h18,
   parameter int            SLOT_W    = 5,
   localparam int           LINE_W    = $clog2(NUM_LINES),
   localparam int           PIN_W     = $clog2(NUM_PIRQ)
)(
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              addr,
   input logic [NUM_PIRQ-1:0][SEL_W-1:0] route_q,
   input logic [NUM_PIRQ-1:0]            pirq_lvl,
   input logic [NUM_LINES-1:0]           irq_out,
   input logic [PIN_W-1:0]               query_pin,
   input logic                           query_en,
   input logic [LINE_W-1:0]              query_line,
   input logic [SLOT_W-1:0]              slot_num,
   input logic [1:0]                     slot_pin,
   input logic [1:0]                     slot_pirq
);
   logic all_off;
   always_comb begin
      all_off = 1'b1;
      for (int p = 0; p < NUM_PIRQ; p++)
         if (int'(route_q[p]) < NUM_LINES) all_off = 1'b0;
   end

   // R2 / R6: with every route parked and no write, nothing can be asserted
   p_parked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (all_off && !wr_en) |=> (irq_out == '0));

   // R4: no request level means no destination one edge later
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_lvl == '0) |=> (irq_out == '0));

   // R4: four sources can light at most four destinations
   p_out_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_out) <= NUM_PIRQ);

   // R10: selectors hold without a write to their word
   p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == BASE_WORD) |=> $stable(route_q));

   // R8: a disabled query reports an all-ones line
   p_query_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !query_en |-> (query_line == '1));

   // R7: the distance from pin to result equals slot minus one, modulo 4
   p_swizzle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (2'(slot_pirq - slot_pin) == 2'(slot_num[1:0] - 2'd1)));

   // R8: an enabled query names a line that the queried selector holds
   p_query_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      query_en |-> (int'(route_q[query_pin]) == int'(query_line)));
endmodule

bind pirq_router pirq_router_chk #(
   .NUM_PIRQ (NUM_PIRQ), .NUM_LINES (NUM_LINES), .SEL_W (SEL_W),
   .ADDR_W (ADDR_W), .BASE_WORD (BASE_WORD), .SLOT_W (SLOT_W)
) u_pirq_router_chk (
   .clk, .rst_n, .wr_en, .addr, .route_q, .pirq_lvl, .irq_out,
   .query_pin, .query_en, .query_line, .slot_num, .slot_pin, .slot_pirq
);

// File: tb/test_pirq_router.sv
module test_pirq_router;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  addr;
   logic [31:0] wr_data;
   logic [3:0]  wr_strb;
   logic [31:0] rd_data;
   logic [3:0]  pirq_lvl;
   logic [15:0] irq_out;
   logic [1:0]  query_pin;
   logic        query_en;
   logic [3:0]  query_line;
   logic [4:0]  slot_num;
   logic [1:0]  slot_pin;
   logic [1:0]  slot_pirq;

   always #5 clk = ~clk;

   pirq_router i_pirq_router (
      .clk, .rst_n, .wr_en, .addr, .wr_data, .wr_strb, .rd_data,
      .pirq_lvl, .irq_out, .query_pin, .query_en, .query_line,
      .slot_num, .slot_pin, .slot_pirq
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference
   int          m_route [4];
   logic [15:0] m_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 4; p++) m_route[p] = 128;
         m_out = '0;
      end else begin
         if (wr_en && addr == 8'h18)
            for (int p = 0; p < 4; p++)
               if (wr_strb[p]) m_route[p] = int'(wr_data[p*8 +: 8]);
         m_out = '0;
         for (int p = 0; p < 4; p++)
            if (pirq_lvl[p] && m_route[p] < 16) m_out[m_route[p]] = 1'b1;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      logic [31:0] e_rd;
      int          e_q;
      e_rd = '0;
      if (addr == 8'h18)
         for (int p = 0; p < 4; p++) e_rd[p*8 +: 8] = 8'(m_route[p]);
      e_q = m_route[query_pin];
      chk(tag, "irq_out", 32'(irq_out), 32'(m_out));
      chk("R10", "rd_data", rd_data, e_rd);
      chk("R8", "query_en", 32'(query_en), 32'(e_q < 16));
      chk("R8", "query_line", 32'(query_line), (e_q < 16) ? 32'(e_q) : 32'hF);
      chk("R7", "slot_pirq", 32'(slot_pirq),
          32'((int'(slot_pin) + int'(slot_num) - 1 + 4) % 4));
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic wr(logic [31:0] d, logic [3:0] s, string tag);
      wr_en = 1'b1; addr = 8'h18; wr_data = d; wr_strb = s;
      tick(tag);
      wr_en = 1'b0; wr_strb = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; addr = 8'h18; wr_data = '0; wr_strb = '0;
      pirq_lvl = '0; query_pin = '0; slot_num = '0; slot_pin = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R3: reset state
      tick("R3");
      chk("R3", "rd_data after reset", rd_data, 32'h8080_8080);
      chk("R3", "irq_out after reset", 32'(irq_out), 32'h0);
      pirq_lvl = 4'hF;
      tick("R3");
      chk("R3", "parked lines stay quiet", 32'(irq_out), 32'h0);
      pirq_lvl = '0;
      tick("R3");

      // R9: single lane write
      wr(32'h0000_0003, 4'b0001, "R9");
      chk("R9", "lane 0 only", rd_data, 32'h8080_8003);
      // R11: registered output, no change before the edge
      pirq_lvl = 4'b0001;
      #1 chk("R11", "before edge", 32'(irq_out), 32'h0);
      tick("R11");
      chk("R1", "line 3 from pirq A", 32'(irq_out), 32'h0008);
      // R4: two sources share line 3
      wr(32'h0000_0300, 4'b0010, "R4");
      pirq_lvl = 4'b0011;
      tick("R4");
      pirq_lvl = 4'b0010;
      tick("R4");
      chk("R4", "shared line held by B", 32'(irq_out), 32'h0008);
      pirq_lvl = 4'b0011;
      tick("R4");
      // R5: move A to line 9, line 3 held by B
      wr(32'h0000_0009, 4'b0001, "R5");
      chk("R5", "moved A, shared kept", 32'(irq_out), 32'h0208);
      // R5: park B while high, line 3 released on same edge
      wr(32'h0000_8000, 4'b0010, "R5");
      chk("R5", "stale line released", 32'(irq_out), 32'h0200);
      // R6: toggling parked B does nothing
      pirq_lvl = 4'b0001;
      tick("R6");
      pirq_lvl = 4'b0011;
      tick("R6");
      chk("R6", "parked toggle", 32'(irq_out), 32'h0200);
      // R2: boundary codes 16 and 255, and 15 valid
      wr(32'h0000_0010, 4'b0001, "R2");
      chk("R2", "code 16 disables", 32'(irq_out), 32'h0);
      wr(32'h0000_00FF, 4'b0001, "R2");
      chk("R2", "code 255 disables", 32'(irq_out), 32'h0);
      chk("R10", "readback of 0xFF", rd_data, 32'h8080_80FF);
      wr(32'h0000_000F, 4'b0001, "R1");
      chk("R1", "code 15 valid", 32'(irq_out), 32'h8000);
      // R9: full word write
      wr(32'h0F0A_0500, 4'hF, "R9");
      chk("R9", "full word readback", rd_data, 32'h0F0A_0500);
      pirq_lvl = 4'hF;
      tick("R1");
      chk("R1", "four distinct lines", 32'(irq_out), 32'h8421);
      // R9: write to another word is ignored
      wr_en = 1'b1; addr = 8'h19; wr_data = 32'h0101_0101; wr_strb = 4'hF;
      tick("R10");
      chk("R10", "other word reads zero", rd_data, 32'h0);
      wr_en = 1'b0; addr = 8'h18;
      tick("R9");
      chk("R9", "other word write ignored", rd_data, 32'h0F0A_0500);
      // R8 / R7 sweeps
      wr(32'h8003_FF07, 4'hF, "R8");
      for (int q = 0; q < 4; q++) begin
         query_pin = 2'(q);
         tick("R8");
      end
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) begin
            slot_num = 5'(s); slot_pin = 2'(p);
            #1 chk("R7", "swizzle", 32'(slot_pirq), 32'((p + s + 3) % 4));
            tick("R7");
         end
      // random mixed traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         for (int b = 0; b < 4; b++)
            d[b*8 +: 8] = ($urandom_range(0, 9) < 7) ? 8'($urandom_range(0, 15))
                                                     : 8'($urandom);
         wr_en     = ($urandom_range(0, 3) == 0);
         addr      = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h18;
         wr_data   = d;
         wr_strb   = 4'($urandom);
         pirq_lvl  = 4'($urandom);
         query_pin = 2'($urandom);
         slot_num  = 5'($urandom);
         slot_pin  = 2'($urandom);
         tick("R4");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule